// File: doc/BRIEF.md
# Bus Master Abort Timeout Detector

This block watches each bus transaction that the local device starts as a bus master. It decides whether a target claimed the cycle in time. The first clock edge that samples `start_i` high is counted as clock 0. Counting starts there and the block looks for a target select on each later edge. The limit is short for a single-address cycle and one clock longer for a dual-address cycle.

When no target answers within the limit, the block declares a master abort and gives up the transaction. It does not retry. It sends a one-clock report to the status logic, requests release of the bus one clock later and raises a halted level. While halted, the block ignores new transaction starts, so no abort can be reported for them. The halt lasts until software pulses the clear input.

Top module: `mabort_watch`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it, `abort_o`, `release_o` and `halted_o` are 0.
- R2: With `dual_i` = 0 at the start edge, an unclaimed transaction raises `abort_o` in the cycle that follows the 6th clock edge after the start edge.
- R3: With `dual_i` = 1 at the start edge, an unclaimed transaction raises `abort_o` in the cycle that follows the 7th clock edge after the start edge.
- R4: `claim_i` sampled high on any edge from the 1st up to and including the limit edge ends the watch, and no abort follows. This also holds when the claim comes exactly on the limit edge.
- R5: `abort_o` is high for exactly one cycle per master abort.
- R6: `release_o` is high for exactly one cycle: the cycle right after the `abort_o` pulse.
- R7: `halted_o` rises in the same cycle as `abort_o`. It then stays high until an edge that samples `clear_i` high, and it is 0 after that edge.
- R8: A start sampled while `halted_o` is high is ignored. It is not retried and no abort is reported for it.
- R9: A new start sampled while a watch is running restarts the window from that edge.
- R10: If `clear_i` is sampled on the same edge that detects a master abort, the abort wins and `halted_o` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low bus reset |
| start_i | input | 1 | High on the clock where the master asserts the frame signal |
| claim_i | input | 1 | High when target select is sampled asserted |
| dual_i | input | 1 | Transaction uses a dual-address cycle; sampled with `start_i` |
| clear_i | input | 1 | Software clear of the abort condition |
| abort_o | output | 1 | One-clock master-abort report to the status register |
| release_o | output | 1 | One-clock request to release the bus |
| halted_o | output | 1 | Master transactions blocked until cleared |

## Verification
Transactions are driven in both address modes. Each one either has a claim at an early edge, a claim exactly on the limit edge, a claim one edge past the limit, or no claim at all. These cases show where the window ends for each mode and separate a 6-clock limit from a 7-clock one. A scoreboard records the clock cycle in which each abort must appear. This catches aborts that come a cycle early or late, as well as missing or extra aborts. Further sequences cover a start while halted, a restart in the middle of a window, and a clear that lands on the abort edge. These show that the halt blocks new starts, that a new start resets the count, and that an abort takes priority over a clear.

// File: rtl/mabort_pkg.sv
package mabort_pkg;
   typedef enum logic {
      ADDR_SINGLE = 1'b0,
      ADDR_DUAL   = 1'b1
   } addr_kind_e;
endpackage

// File: rtl/mabort_timer.sv
module mabort_timer
   import mabort_pkg::*;
#(
   parameter int SAC_LIMIT = 6,
   parameter int DAC_LIMIT = 7,
   parameter int CNT_W     = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_ok,
   input  logic dual,
   input  logic claim,
   output logic expire
);
   logic             busy_q;
   logic [CNT_W-1:0] cnt_q;
   addr_kind_e       kind_q;
   logic [CNT_W-1:0] lim;

   assign lim    = (kind_q == ADDR_DUAL) ? CNT_W'(DAC_LIMIT) : CNT_W'(SAC_LIMIT);
   assign expire = busy_q && !claim && (cnt_q == lim);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
         kind_q <= ADDR_SINGLE;
      end else if (start_ok) begin
         busy_q <= 1'b1;
         cnt_q  <= CNT_W'(1);
         kind_q <= dual ? ADDR_DUAL : ADDR_SINGLE;
      end else if (busy_q) begin
         if (claim || expire) begin
            busy_q <= 1'b0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end
endmodule

// File: rtl/mabort_halt.sv
module mabort_halt (
   input  logic clk,
   input  logic rst_n,
   input  logic expire,
   input  logic clear,
   output logic abort_q,
   output logic halted_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         abort_q  <= 1'b0;
         halted_q <= 1'b0;
      end else begin
         abort_q <= expire;
         if (expire) begin
            halted_q <= 1'b1;
         end else if (clear) begin
            halted_q <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/mabort_release.sv
module mabort_release #(
   parameter int REL_DELAY = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic abort,
   output logic rel
);
   generate
      if (REL_DELAY == 0) begin : g_direct
         assign rel = abort;
      end else begin : g_piped
         logic [REL_DELAY-1:0] pipe_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               pipe_q <= '0;
            end else begin
               pipe_q <= {pipe_q[REL_DELAY-1:0], abort} >> 0;
            end
         end
         assign rel = pipe_q[REL_DELAY-1];
      end
   endgenerate
endmodule

// File: rtl/mabort_watch.sv
module mabort_watch #(
   parameter int SAC_LIMIT = 6,
   parameter int DAC_LIMIT = 7,
   parameter int REL_DELAY = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   input  logic claim_i,
   input  logic dual_i,
   input  logic clear_i,
   output logic abort_o,
   output logic release_o,
   output logic halted_o
);
   localparam int CNT_W = $clog2(DAC_LIMIT + 1);

   generate
      if (SAC_LIMIT < 1) begin : g_bad_sac
         $error("SAC_LIMIT must be at least 1");
      end
      if (DAC_LIMIT < SAC_LIMIT) begin : g_bad_dac
         $error("DAC_LIMIT must not be below SAC_LIMIT");
      end
      if (REL_DELAY < 0 || REL_DELAY > 8) begin : g_bad_rel
         $error("REL_DELAY must lie in 0..8");
      end
   endgenerate

   logic expire;
   logic start_ok;

   assign start_ok = start_i && !halted_o;

   mabort_timer #(
      .SAC_LIMIT(SAC_LIMIT),
      .DAC_LIMIT(DAC_LIMIT),
      .CNT_W    (CNT_W)
   ) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_ok(start_ok),
      .dual    (dual_i),
      .claim   (claim_i),
      .expire  (expire)
   );

   mabort_halt u_halt (
      .clk     (clk),
      .rst_n   (rst_n),
      .expire  (expire),
      .clear   (clear_i),
      .abort_q (abort_o),
      .halted_q(halted_o)
   );

   mabort_release #(
      .REL_DELAY(REL_DELAY)
   ) u_rel (
      .clk  (clk),
      .rst_n(rst_n),
      .abort(abort_o),
      .rel  (release_o)
   );
endmodule

// File: rtl/mabort_watch_chk.sv
module mabort_watch_chk #(
   parameter int REL_DELAY = 1
) (
   input logic clk,
   input logic rst_n,
   input logic claim_i,
   input logic clear_i,
   input logic abort_o,
   input logic release_o,
   input logic halted_o
);
   // R5
   abort_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      abort_o |=> !abort_o);

   // R7
   halt_with_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
      abort_o |-> halted_o);

   // R7
   halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (halted_o && !clear_i) |=> halted_o);

   // R7
   halt_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(halted_o) |-> abort_o);

   // R4
   claim_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      abort_o |-> !$past(claim_i));

   generate
      if (REL_DELAY == 1) begin : g_rel1
         // R6
         release_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
            abort_o |=> release_o);
         // R6
         release_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
            release_o |-> $past(abort_o));
      end
   endgenerate
endmodule

bind mabort_watch mabort_watch_chk #(.REL_DELAY(REL_DELAY)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .claim_i  (claim_i),
   .clear_i  (clear_i),
   .abort_o  (abort_o),
   .release_o(release_o),
   .halted_o (halted_o)
);

// File: tb/mabort_watch_test.sv
module mabort_watch_test;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start_i = 1'b0, claim_i = 1'b0, dual_i = 1'b0, clear_i = 1'b0;
   logic abort_o, release_o, halted_o;

   int cyc = 0;
   int checks = 0;
   int errors = 0;
   bit halted_exp = 1'b0;
   bit pend_rel = 1'b0;
   bit prev_abort = 1'b0;
   bit done = 1'b0;
   int exp_q[$];

   always #2 clk = ~clk;

   mabort_watch uut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .claim_i(claim_i),
      .dual_i(dual_i), .clear_i(clear_i), .abort_o(abort_o),
      .release_o(release_o), .halted_o(halted_o)
   );

   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   // monitor: scoreboard for abort timing (R2, R3), pulse width (R5), release (R6)
   always @(negedge clk) begin
      if (rst_n) begin
         if (abort_o) begin
            if (prev_abort) check("R5 abort width", 2, 1);
            if (exp_q.size() == 0) check("R2/R3 unexpected abort cycle", cyc, -1);
            else check("R2/R3 abort cycle", cyc, exp_q.pop_front());
         end
         if (pend_rel) check("R6 release after abort", int'(release_o), 1);
         else if (release_o) check("R6 stray release", 1, 0);
         pend_rel   = abort_o;
         prev_abort = abort_o;
      end
   end

   always @(posedge clk) begin
      if (cyc > 5000 && !done) begin
         done = 1'b1;
         errors++;
         checks++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   task automatic run_txn(input bit dual, input int claim_at, input int clr_at);
      int lim = dual ? 7 : 6;
      bit aborts;
      @(negedge clk);
      start_i = 1'b1; dual_i = dual; claim_i = 1'b0;
      aborts = !halted_exp && !(claim_at >= 1 && claim_at <= lim);
      if (aborts) exp_q.push_back(cyc + 1 + lim);
      @(negedge clk);
      start_i = 1'b0;
      for (int k = 1; k <= lim + 3; k++) begin
         claim_i = (k == claim_at);
         clear_i = (k == clr_at);
         @(negedge clk);
      end
      claim_i = 1'b0; clear_i = 1'b0;
      if (aborts) halted_exp = 1'b1;
      @(negedge clk);
      check("R7/R8 halted after transaction", int'(halted_o), int'(halted_exp));
   endtask

   task automatic sw_clear();
      @(negedge clk); clear_i = 1'b1;
      @(negedge clk); clear_i = 1'b0;
      halted_exp = 1'b0;
      check("R7 halted cleared", int'(halted_o), 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check("R1 abort in reset", int'(abort_o), 0);
      check("R1 halted in reset", int'(halted_o), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 release after reset", int'(release_o), 0);

      run_txn(1'b0, 3, 0);   // R4 early claim
      run_txn(1'b0, 6, 0);   // R4 claim on limit edge, single
      run_txn(1'b1, 7, 0);   // R4 claim on limit edge, dual
      run_txn(1'b0, 0, 0);   // R2 unclaimed single
      run_txn(1'b0, 0, 0);   // R8 start while halted ignored
      sw_clear();            // R7
      run_txn(1'b1, 8, 0);   // R3 claim one edge too late
      sw_clear();
      run_txn(1'b0, 7, 0);   // R2 claim one edge too late, single
      sw_clear();
      run_txn(1'b1, 0, 7);   // R10 clear on the abort edge; R3
      check("R10 halted kept", int'(halted_o), 1);
      sw_clear();

      // R9 restart in mid-window
      @(negedge clk); start_i = 1'b1; dual_i = 1'b0;
      @(negedge clk); start_i = 1'b0;
      repeat (2) @(negedge clk);
      start_i = 1'b1;
      exp_q.push_back(cyc + 1 + 6);
      @(negedge clk); start_i = 1'b0;
      repeat (12) @(negedge clk);
      check("R9 halted after restart abort", int'(halted_o), 1);

      check("R2/R3 no missing aborts", exp_q.size(), 0);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule